// File: doc/BRIEF.md
# Programmable Bidirectional I/O Cell

This block is a bank of configurable pad cells. Each pin has its own configuration: an input capture style, an output direction mode and an output drive style. On the input side the core can receive the pad value directly (purely combinational), as sampled by a flip-flop on the rising edge of the dedicated I/O clock, or through a level-sensitive latch that is open while that clock is high. On the output side a pin can be input-only, always driving, or bidirectional with its enable taken from the core.

The drive style is either push-pull (drives both levels) or open-drain. Open-drain is built on the output-enable: the cell only ever pulls the pad low, and for a logic one it releases the pad so an external pull-up sets the level. The pad is modelled as three separate signals: value in, value out and output enable. A configuration of all zeros gives a safe default: an input-only pin with a direct input path and a push-pull style.

Top module: `pio_bank`

## Requirements
- R1: With all configuration bits zero and reset applied, every `pad_oe` bit is 0, `to_core` equals `pad_in`, and the input flip-flop and latch of every pin read as 0 when selected.
- R2: Input select code 2'b00 (and reserved code 2'b11) passes `pad_in` to `to_core` combinationally. Pin i's input select is `cfg_in_sel[2*i+1:2*i]`.
- R3: Input select code 2'b01 presents on `to_core` the value `pad_in` had at the most recent rising edge of `io_clk`.
- R4: Input select code 2'b10 presents a latch that follows `pad_in` while `io_clk` is high and holds its last value while `io_clk` is low.
- R5: Direction code 2'b00 (input only) and reserved code 2'b11 keep `pad_oe` at 0 whatever `core_out`, `core_oe` and `cfg_od` are. Pin i's direction is `cfg_dir_sel[2*i+1:2*i]`.
- R6: Direction code 2'b01 (output) enables the output function at all times. With push-pull style `pad_oe` is 1.
- R7: Direction code 2'b10 (bidirectional) enables the output function exactly when `core_oe` is 1. With push-pull style `pad_oe` equals `core_oe`.
- R8: With `cfg_od` bit set to 1 (open-drain), `pad_out` is always 0. `pad_oe` is 1 only when the output function is enabled and `core_out` is 0; otherwise the pad is released.
- R9: With `cfg_od` bit 0 (push-pull, the default), `pad_out` equals `core_out`.
- R10: Asserting `rst_n` low clears the input flip-flop and latch of every pin at once, without waiting for a clock edge.
- R11: Each pin's outputs depend only on that pin's configuration, core signals and pad input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | 1 | Dedicated I/O clock for the input flip-flop and latch |
| rst_n | input | 1 | Asynchronous active-low reset of the input storage |
| cfg_in_sel | input | 2*NPINS | Per-pin input capture select, 2 bits per pin |
| cfg_dir_sel | input | 2*NPINS | Per-pin direction mode, 2 bits per pin |
| cfg_od | input | NPINS | Per-pin drive style: 0 push-pull, 1 open-drain |
| core_out | input | NPINS | Data from the core to drive on the pad |
| core_oe | input | NPINS | Core output enable used in bidirectional mode |
| pad_in | input | NPINS | Value seen on the pad |
| to_core | output | NPINS | Captured pad value delivered to the core |
| pad_out | output | NPINS | Value driven onto the pad when enabled |
| pad_oe | output | NPINS | Pad output-driver enable |

## Verification
The assertions take for granted that `pad_in` and the configuration are steady around each rising edge of `io_clk`, so that the sampled flip-flop value matches the pad value of the previous edge. They also assume the latch check on the falling edge sees a pad value that was set during the high phase. The stimulus changes configuration, core data and pad values only in the low phase of the clock. It changes `pad_in` a second time only just after a rising edge, which splits latch behaviour from flip-flop behaviour while keeping the flip-flop's sampling window clean. Reset is applied and released only during the low phase.

// File: rtl/pio_pkg.sv
package pio_pkg;

   typedef enum logic [1:0] {
      IN_DIRECT = 2'b00,
      IN_FLOP   = 2'b01,
      IN_LATCH  = 2'b10,
      IN_RSVD   = 2'b11
   } in_sel_e;

   typedef enum logic [1:0] {
      DIR_INPUT = 2'b00,
      DIR_OUT   = 2'b01,
      DIR_BIDIR = 2'b10,
      DIR_RSVD  = 2'b11
   } dir_sel_e;

   localparam int SEL_W = 2;

   typedef struct packed {
      logic     od;
      dir_sel_e dir;
      in_sel_e  ins;
   } pin_cfg_t;

endpackage

// File: rtl/pio_in_path.sv
module pio_in_path
   import pio_pkg::*;
(
   input  logic    io_clk,
   input  logic    rst_n,
   input  in_sel_e ins,
   input  logic    pad_in,
   output logic    to_core
);

   logic flop_q;
   logic latch_q;

   // edge-sampled capture on the dedicated I/O clock
   always_ff @(posedge io_clk or negedge rst_n) begin
      if (!rst_n) flop_q <= 1'b0;
      else        flop_q <= pad_in;
   end

   // level-sensitive capture: open while the clock is high
   always_latch begin
      if (!rst_n)      latch_q = 1'b0;
      else if (io_clk) latch_q = pad_in;
   end

   always_comb begin
      unique case (ins)
         IN_FLOP:  to_core = flop_q;
         IN_LATCH: to_core = latch_q;
         default:  to_core = pad_in;
      endcase
   end

endmodule

// File: rtl/pio_out_drv.sv
module pio_out_drv
   import pio_pkg::*;
(
   input  dir_sel_e dir,
   input  logic     od,
   input  logic     core_out,
   input  logic     core_oe,
   output logic     pad_out,
   output logic     pad_oe
);

   logic func_en;

   always_comb begin
      unique case (dir)
         DIR_OUT:   func_en = 1'b1;
         DIR_BIDIR: func_en = core_oe;
         default:   func_en = 1'b0;
      endcase
   end

   always_comb begin
      if (od) begin
         // only ever pull low; a one releases the pad
         pad_out = 1'b0;
         pad_oe  = func_en & ~core_out;
      end else begin
         pad_out = core_out;
         pad_oe  = func_en;
      end
   end

endmodule

// File: rtl/pio_cell.sv
module pio_cell
   import pio_pkg::*;
(
   input  logic     io_clk,
   input  logic     rst_n,
   input  pin_cfg_t cfg,
   input  logic     core_out,
   input  logic     core_oe,
   input  logic     pad_in,
   output logic     to_core,
   output logic     pad_out,
   output logic     pad_oe
);

   pio_in_path u_in (
      .io_clk  (io_clk),
      .rst_n   (rst_n),
      .ins     (cfg.ins),
      .pad_in  (pad_in),
      .to_core (to_core)
   );

   pio_out_drv u_out (
      .dir      (cfg.dir),
      .od       (cfg.od),
      .core_out (core_out),
      .core_oe  (core_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_pkg::*;
#(
   parameter int NPINS = 4
) (
   input  logic                   io_clk,
   input  logic                   rst_n,
   input  logic [SEL_W*NPINS-1:0] cfg_in_sel,
   input  logic [SEL_W*NPINS-1:0] cfg_dir_sel,
   input  logic [NPINS-1:0]       cfg_od,
   input  logic [NPINS-1:0]       core_out,
   input  logic [NPINS-1:0]       core_oe,
   input  logic [NPINS-1:0]       pad_in,
   output logic [NPINS-1:0]       to_core,
   output logic [NPINS-1:0]       pad_out,
   output logic [NPINS-1:0]       pad_oe
);

   initial begin
      assert (NPINS >= 1 && NPINS <= 256)
         else $error("pio_bank: NPINS must lie in 1..256");
   end

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      pin_cfg_t pin_cfg;

      assign pin_cfg.od  = cfg_od[g];
      assign pin_cfg.dir = dir_sel_e'(cfg_dir_sel[SEL_W*g +: SEL_W]);
      assign pin_cfg.ins = in_sel_e'(cfg_in_sel[SEL_W*g +: SEL_W]);

      pio_cell u_cell (
         .io_clk   (io_clk),
         .rst_n    (rst_n),
         .cfg      (pin_cfg),
         .core_out (core_out[g]),
         .core_oe  (core_oe[g]),
         .pad_in   (pad_in[g]),
         .to_core  (to_core[g]),
         .pad_out  (pad_out[g]),
         .pad_oe   (pad_oe[g])
      );
   end

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
   parameter int NPINS = 4
) (
   input logic                 io_clk,
   input logic                 rst_n,
   input logic [2*NPINS-1:0]   cfg_in_sel,
   input logic [2*NPINS-1:0]   cfg_dir_sel,
   input logic [NPINS-1:0]     cfg_od,
   input logic [NPINS-1:0]     core_out,
   input logic [NPINS-1:0]     core_oe,
   input logic [NPINS-1:0]     pad_in,
   input logic [NPINS-1:0]     to_core,
   input logic [NPINS-1:0]     pad_out,
   input logic [NPINS-1:0]     pad_oe
);

   logic past_valid;

   always_ff @(posedge io_clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   for (genvar g = 0; g < NPINS; g++) begin : g_chk
      // R5: input-only and reserved direction never drive
      a_r5_input_only_no_drive: assert property (@(posedge io_clk) disable iff (!rst_n)
         (cfg_dir_sel[2*g +: 2] == 2'b00 || cfg_dir_sel[2*g +: 2] == 2'b11) |-> !pad_oe[g]);

      // R8: open-drain never drives a one
      a_r8_od_no_high: assert property (@(posedge io_clk) disable iff (!rst_n)
         cfg_od[g] |-> !(pad_oe[g] && pad_out[g]));

      // R8: open-drain releases the pad for a one
      a_r8_od_release: assert property (@(posedge io_clk) disable iff (!rst_n)
         (cfg_od[g] && core_out[g]) |-> !pad_oe[g]);

      // R7: push-pull bidirectional enable follows the core
      a_r7_bidir_follows: assert property (@(posedge io_clk) disable iff (!rst_n)
         (cfg_dir_sel[2*g +: 2] == 2'b10 && !cfg_od[g]) |-> pad_oe[g] == core_oe[g]);

      // R2: direct input path
      a_r2_direct: assert property (@(posedge io_clk) disable iff (!rst_n)
         (cfg_in_sel[2*g +: 2] == 2'b00) |-> to_core[g] == pad_in[g]);

      // R3: flop shows the pad value of the previous rising edge
      a_r3_flop_capture: assert property (@(posedge io_clk) disable iff (!rst_n)
         (past_valid && cfg_in_sel[2*g +: 2] == 2'b01) |-> to_core[g] == $past(pad_in[g]));

      // R4: latch is transparent up to the end of the high phase
      a_r4_latch_open: assert property (@(negedge io_clk) disable iff (!rst_n)
         (cfg_in_sel[2*g +: 2] == 2'b10) |-> to_core[g] == pad_in[g]);
   end

endmodule

bind pio_bank pio_bank_chk #(.NPINS(NPINS)) u_chk (
   .io_clk      (io_clk),
   .rst_n       (rst_n),
   .cfg_in_sel  (cfg_in_sel),
   .cfg_dir_sel (cfg_dir_sel),
   .cfg_od      (cfg_od),
   .core_out    (core_out),
   .core_oe     (core_oe),
   .pad_in      (pad_in),
   .to_core     (to_core),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe)
);

// File: tb/pio_bank_tb.sv
module pio_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N = 4;

   logic           io_clk = 1'b0;
   logic           rst_n  = 1'b0;
   logic [2*N-1:0] cfg_in_sel  = '0;
   logic [2*N-1:0] cfg_dir_sel = '0;
   logic [N-1:0]   cfg_od   = '0;
   logic [N-1:0]   core_out = '0;
   logic [N-1:0]   core_oe  = '0;
   logic [N-1:0]   pad_in   = '0;
   logic [N-1:0]   to_core, pad_out, pad_oe;

   int checks = 0;
   int errors = 0;
   bit m_flop [N];
   bit m_lat  [N];

   always #(CLK_PERIOD/2) io_clk = ~io_clk;

   pio_bank #(.NPINS(N)) u_dut (
      .io_clk(io_clk), .rst_n(rst_n),
      .cfg_in_sel(cfg_in_sel), .cfg_dir_sel(cfg_dir_sel), .cfg_od(cfg_od),
      .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
      .to_core(to_core), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string tag, input string what, input int pin,
                      input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s pin %0d actual %b expected %b at %0t",
                  tag, what, pin, act, exp, $time);
      end
   endtask

   // reference model: compares every output of every pin
   task automatic check_all(input string force_tag);
      for (int i = 0; i < N; i++) begin
         logic [1:0] ins = cfg_in_sel[2*i +: 2];
         logic [1:0] dir = cfg_dir_sel[2*i +: 2];
         logic od = cfg_od[i];
         logic en = (dir == 2'b01) || (dir == 2'b10 && core_oe[i]);
         logic e_oe = od ? (en && !core_out[i]) : en;
         logic e_out = od ? 1'b0 : core_out[i];
         logic e_core = (ins == 2'b01) ? m_flop[i] :
                        (ins == 2'b10) ? m_lat[i] : pad_in[i];
         string t_oe, t_out, t_core;
         t_oe  = (dir == 2'b00 || dir == 2'b11) ? "R5" : od ? "R8" :
                 (dir == 2'b01) ? "R6" : "R7";
         t_out = od ? "R8" : "R9";
         t_core = (ins == 2'b01) ? "R3" : (ins == 2'b10) ? "R4" : "R2";
         if (force_tag != "") begin
            t_oe = force_tag; t_out = force_tag; t_core = force_tag;
         end
         chk(t_oe, "pad_oe", i, pad_oe[i], e_oe);
         chk(t_out, "pad_out", i, pad_out[i], e_out);
         chk(t_core, "to_core", i, to_core[i], e_core);
      end
   endtask

   // entered during the low phase; pa before the rising edge, pb after it
   task automatic run_cycle(input logic [N-1:0] pa, input logic [N-1:0] pb);
      pad_in = pa;
      #1 check_all("");
      @(posedge io_clk);
      for (int i = 0; i < N; i++) begin m_flop[i] = pa[i]; m_lat[i] = pa[i]; end
      #1 check_all("");
      pad_in = pb;
      for (int i = 0; i < N; i++) m_lat[i] = pb[i];
      #1 check_all("");
      @(negedge io_clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_flop[i] = 0; m_lat[i] = 0; end
      // R1: erased configuration under reset
      #2 check_all("R1");
      pad_in = 4'b1010;
      #1 check_all("R1");
      cfg_in_sel = 8'b10_01_10_01;
      #1 check_all("R1");
      @(posedge io_clk); #1 check_all("R10");
      @(negedge io_clk); #1;
      rst_n = 1'b1;
      cfg_in_sel = '0;

      // main traffic
      for (int c = 0; c < 80; c++) begin
         if (c % 4 == 0) begin
            cfg_in_sel  = 2*N'($urandom);
            cfg_dir_sel = 2*N'($urandom);
            cfg_od      = N'($urandom);
         end
         core_out = N'($urandom);
         core_oe  = N'($urandom);
         run_cycle(N'($urandom), N'($urandom));
      end

      // R4: latch holds through the low phase while the pad changes
      cfg_in_sel = 8'b10_10_10_10;
      run_cycle(4'b0000, 4'b1111);
      pad_in = 4'b0000;
      #1 check_all("R4");

      // R10: asynchronous reset clears flop and latch mid-run
      cfg_in_sel = 8'b10_01_10_01;
      run_cycle(4'b1111, 4'b1111);
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) begin m_flop[i] = 0; m_lat[i] = 0; end
      #1 check_all("R10");
      @(negedge io_clk); #1;
      rst_n = 1'b1;

      // R11: mixed per-pin setups stay independent
      cfg_in_sel  = 8'b00_10_01_00;
      cfg_dir_sel = 8'b01_10_00_01;
      cfg_od      = 4'b1100;
      core_out    = 4'b1111;
      core_oe     = 4'b0000;
      #1 check_all("R11");
      core_out    = 4'b0000;
      core_oe     = 4'b0100;
      #1 check_all("R11");
      run_cycle(4'b0110, 4'b1001);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule